// File: doc/BRIEF.md
# Dual-Core Split/Lockstep Mode Controller

This block sits between two identical processor cores and two single-ported, synchronous memory banks. It also drives the reset of each core. The operating mode is captured from a select pin while the subsystem reset is asserted, and it stays frozen until the next reset.

In split mode each core owns one bank and one response channel. There is no coherence logic between the two. Core 1 can only leave reset after core 0 has left it. An attempt to release core 1 while core 0 is still held is refused and recorded in a sticky status bit.

In lockstep mode both cores leave reset together. Core 1 acts only as a shadow copy of core 0:
- Core 1's request bundle is compared against core 0's on every cycle, and any difference latches an error flag.
- Core 1's memory requests are discarded and its response outputs stay at zero.
- Bank 1 is mapped directly above bank 0 behind core 0's port, so core 0 sees twice the storage of one bank.

Each bank holds 2^BANK_AW words of DW bits. For example, BANK_AW=14 with 32-bit words gives 64 KB per bank and 128 KB stacked.

Top module: `dcl_pair_ctrl`

## Requirements
- R1: `lockstep_o` follows `lockstep_sel_i` on every clock edge while `rst_n` is low. From the first edge with `rst_n` high until the next reset, `lockstep_o` does not change, whatever `lockstep_sel_i` does.
- R2: In split mode, a request with address bit [AW-1]=0 reaches the core's own bank at word address [AW-2:0].
  - A write stores byte lane i (bits 8i+7:8i) only where `be[i]`=1.
  - A read returns the word last written by that same core.
  - Writes by the other core to the same address have no effect on it.
- R3: `c1_rst_n_o` is never high while `c0_rst_n_o` is low.
- R4: In split mode, `c0_rst_n_o` is set on the edge that samples `c0_run_i` high. `c1_rst_n_o` is set no earlier than one edge after `c0_rst_n_o` went high, and only while both run inputs are high. Dropping `c0_run_i` lowers both reset outputs on the next edge.
- R5: In lockstep mode, both reset outputs go high on the same edge that samples `c0_run_i` high, and `c1_run_i` has no effect.
- R6: In split mode, sampling `c1_run_i`=1 while `c0_run_i`=0 sets `seq_viol_o` on the next edge. The bit stays set until reset. It is never set in lockstep mode.
- R7: While lockstep mode is active and both cores are out of reset, any of the following sets `lock_mismatch_o` on the next edge:
  - a difference between the two ports in req, we, addr or be;
  - a difference in wdata while core 0 is writing.
  The flag stays set until reset.
- R8: A difference in wdata while core 0's req=1 and we=0 does not set `lock_mismatch_o`.
- R9: In lockstep mode, `c1_rvalid_o`, `c1_aerr_o` and `c1_rdata_o` stay 0. Core 1's requests leave both banks unchanged.
- R10: In lockstep mode, core 0 address bit [AW-1] selects bank 0 (0) or bank 1 (1). A location of bank 1 written this way is the one core 1 reads at the same low address in split mode.
- R11: In split mode, a request with address bit [AW-1]=1 produces a response with rvalid=1, aerr=1 and rdata=0, and writes nothing.
- R12: An accepted request gives rvalid=1 exactly one edge later, with read data on the same cycle. A request from a core held in reset gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous subsystem reset, active low |
| lockstep_sel_i | input | 1 | Mode select sampled in reset: 1 = lockstep, 0 = split |
| c0_run_i | input | 1 | Release request for core 0 |
| c1_run_i | input | 1 | Release request for core 1 |
| c0_rst_n_o | output | 1 | Core 0 reset, active low |
| c1_rst_n_o | output | 1 | Core 1 reset, active low |
| lockstep_o | output | 1 | Latched mode |
| seq_viol_o | output | 1 | Sticky release-order violation |
| lock_mismatch_o | output | 1 | Sticky lockstep compare error |
| c0_req_i | input | 1 | Core 0 request valid |
| c0_we_i | input | 1 | Core 0 write enable |
| c0_addr_i | input | BANK_AW+1 | Core 0 word address |
| c0_wdata_i | input | DW | Core 0 write data |
| c0_be_i | input | DW/8 | Core 0 byte strobes |
| c0_rvalid_o | output | 1 | Core 0 response valid |
| c0_rdata_o | output | DW | Core 0 read data |
| c0_aerr_o | output | 1 | Core 0 address error |
| c1_req_i | input | 1 | Core 1 request valid |
| c1_we_i | input | 1 | Core 1 write enable |
| c1_addr_i | input | BANK_AW+1 | Core 1 word address |
| c1_wdata_i | input | DW | Core 1 write data |
| c1_be_i | input | DW/8 | Core 1 byte strobes |
| c1_rvalid_o | output | 1 | Core 1 response valid |
| c1_rdata_o | output | DW | Core 1 read data |
| c1_aerr_o | output | 1 | Core 1 address error |

## Verification
The bench builds the block with BANK_AW=3 and DW=32, so each bank holds eight words. At this size every in-range and out-of-range address of both ports can be swept, in both modes, along with all sixteen byte-strobe patterns.

Memory survives reset, so the bench writes the upper stacked half in lockstep and then reads it back as core 1's own bank in split mode. Each compared field is mismatched on its own behind a fresh reset, which shows that the sticky flag is raised by that field alone.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

    // Mode and reset-sequencing state
    typedef struct packed {
        logic lock;   // latched mode, 1 = lockstep
        logic rel0;   // core 0 out of reset
        logic rel1;   // core 1 out of reset
        logic viol;   // sticky release-order violation
    } seq_state_t;

    // Per-port response pipeline stage
    typedef struct packed {
        logic vld;    // response due this cycle
        logic err;    // out-of-range access
        logic bank;   // bank that serves the read data
    } rsp_state_t;

endpackage

// File: rtl/dcl_mode_seq.sv
module dcl_mode_seq
    import dcl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_sel_i,
    input  logic run0_i,
    input  logic run1_i,
    output logic lock_o,
    output logic rel0_o,
    output logic rel1_o,
    output logic viol_o
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rel0 = run0_i;
        // Lockstep: the shadow core follows the primary on the same edge.
        // Split: the second core needs the first to be already running.
        st_d.rel1 = st_q.lock ? run0_i : (run1_i & run0_i & st_q.rel0);
        st_d.viol = st_q.viol | (~st_q.lock & run1_i & ~run0_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{lock: lock_sel_i, rel0: 1'b0, rel1: 1'b0, viol: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.lock;
    assign rel0_o = st_q.rel0;
    assign rel1_o = st_q.rel1;
    assign viol_o = st_q.viol;

    assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(st_q.lock));

    assert_c1_needs_c0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rel1 |-> st_q.rel0);

    assert_split_stagger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.lock && $past(rst_n) && $rose(st_q.rel1)) |-> $past(st_q.rel0));

    assert_lock_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |-> (st_q.rel0 == st_q.rel1));

    assert_viol_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.viol |=> st_q.viol);

    assert_viol_never_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |-> !st_q.viol);

endmodule

// File: rtl/dcl_lock_cmp.sv
module dcl_lock_cmp #(
    parameter int AW = 10,
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          a_req_i,
    input  logic          a_we_i,
    input  logic [AW-1:0] a_addr_i,
    input  logic [DW-1:0] a_wdata_i,
    input  logic [BW-1:0] a_be_i,
    input  logic          b_req_i,
    input  logic          b_we_i,
    input  logic [AW-1:0] b_addr_i,
    input  logic [DW-1:0] b_wdata_i,
    input  logic [BW-1:0] b_be_i,
    output logic          mismatch_o
);

    logic diff;
    logic mism_d, mism_q;

    always_comb begin
        diff = (a_req_i != b_req_i) | (a_we_i != b_we_i) |
               (a_addr_i != b_addr_i) | (a_be_i != b_be_i) |
               (a_req_i & a_we_i & (a_wdata_i != b_wdata_i));
        mism_d = mism_q | (en_i & diff);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mism_q <= 1'b0;
        end else begin
            mism_q <= mism_d;
        end
    end

    assign mismatch_o = mism_q;

    assert_mismatch_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mism_q |=> mism_q);

    assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !mism_q) |=> !mism_q);

    assert_read_data_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !mism_q && a_req_i && b_req_i && !a_we_i && !b_we_i &&
         a_addr_i == b_addr_i && a_be_i == b_be_i) |=> !mism_q);

endmodule

// File: rtl/dcl_bank_ram.sv
module dcl_bank_ram #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            en_i,
    input  logic            we_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [DW/8-1:0] be_i,
    output logic [DW-1:0]   rdata_o
);

    localparam int DEPTH = 1 << AW;
    localparam int BW    = DW / 8;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    // Storage array: written in place, so it sits outside the next-state struct.
    always_ff @(posedge clk) begin
        if (en_i) begin
            if (we_i) begin
                for (int b = 0; b < BW; b++) begin
                    if (be_i[b]) begin
                        mem[addr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
                    end
                end
            end else begin
                rdata_q <= mem[addr_i];
            end
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/dcl_pair_ctrl.sv
module dcl_pair_ctrl
    import dcl_pkg::*;
#(
    parameter int BANK_AW = 9,
    parameter int DW      = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lockstep_sel_i,
    input  logic                 c0_run_i,
    input  logic                 c1_run_i,
    output logic                 c0_rst_n_o,
    output logic                 c1_rst_n_o,
    output logic                 lockstep_o,
    output logic                 seq_viol_o,
    output logic                 lock_mismatch_o,
    input  logic                 c0_req_i,
    input  logic                 c0_we_i,
    input  logic [BANK_AW:0]     c0_addr_i,
    input  logic [DW-1:0]        c0_wdata_i,
    input  logic [DW/8-1:0]      c0_be_i,
    output logic                 c0_rvalid_o,
    output logic [DW-1:0]        c0_rdata_o,
    output logic                 c0_aerr_o,
    input  logic                 c1_req_i,
    input  logic                 c1_we_i,
    input  logic [BANK_AW:0]     c1_addr_i,
    input  logic [DW-1:0]        c1_wdata_i,
    input  logic [DW/8-1:0]      c1_be_i,
    output logic                 c1_rvalid_o,
    output logic [DW-1:0]        c1_rdata_o,
    output logic                 c1_aerr_o
);

    localparam int AW    = BANK_AW + 1;
    localparam int BW    = DW / 8;
    localparam int NBANK = 2;

    logic lock, rel0, rel1, viol;

    dcl_mode_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_sel_i (lockstep_sel_i),
        .run0_i     (c0_run_i),
        .run1_i     (c1_run_i),
        .lock_o     (lock),
        .rel0_o     (rel0),
        .rel1_o     (rel1),
        .viol_o     (viol)
    );

    // Request acceptance and bank routing
    logic acc0, acc1, top0, top1;
    logic [NBANK-1:0]   bk_en, bk_we;
    logic [BANK_AW-1:0] bk_addr  [NBANK];
    logic [DW-1:0]      bk_wdata [NBANK];
    logic [DW-1:0]      bk_rdata [NBANK];
    logic [BW-1:0]      bk_be    [NBANK];

    rsp_state_t r0_d, r0_q, r1_d, r1_q;

    always_comb begin
        acc0 = rel0 & c0_req_i;
        acc1 = rel1 & c1_req_i & ~lock;
        top0 = c0_addr_i[AW-1];
        top1 = c1_addr_i[AW-1];

        // Bank 0 is always owned by core 0.
        bk_en[0]    = acc0 & ~top0;
        bk_we[0]    = c0_we_i;
        bk_addr[0]  = c0_addr_i[BANK_AW-1:0];
        bk_wdata[0] = c0_wdata_i;
        bk_be[0]    = c0_be_i;

        // Bank 1 is stacked behind core 0 in lockstep, owned by core 1 otherwise.
        if (lock) begin
            bk_en[1]    = acc0 & top0;
            bk_we[1]    = c0_we_i;
            bk_addr[1]  = c0_addr_i[BANK_AW-1:0];
            bk_wdata[1] = c0_wdata_i;
            bk_be[1]    = c0_be_i;
        end else begin
            bk_en[1]    = acc1 & ~top1;
            bk_we[1]    = c1_we_i;
            bk_addr[1]  = c1_addr_i[BANK_AW-1:0];
            bk_wdata[1] = c1_wdata_i;
            bk_be[1]    = c1_be_i;
        end

        r0_d.vld  = acc0;
        r0_d.err  = acc0 & ~lock & top0;
        r0_d.bank = top0;

        r1_d.vld  = acc1;
        r1_d.err  = acc1 & top1;
        r1_d.bank = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r0_q <= '0;
            r1_q <= '0;
        end else begin
            r0_q <= r0_d;
            r1_q <= r1_d;
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        dcl_bank_ram #(
            .AW (BANK_AW),
            .DW (DW)
        ) u_bank (
            .clk     (clk),
            .en_i    (bk_en[g]),
            .we_i    (bk_we[g]),
            .addr_i  (bk_addr[g]),
            .wdata_i (bk_wdata[g]),
            .be_i    (bk_be[g]),
            .rdata_o (bk_rdata[g])
        );
    end

    dcl_lock_cmp #(
        .AW (AW),
        .DW (DW),
        .BW (BW)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (lock & rel0 & rel1),
        .a_req_i    (c0_req_i),
        .a_we_i     (c0_we_i),
        .a_addr_i   (c0_addr_i),
        .a_wdata_i  (c0_wdata_i),
        .a_be_i     (c0_be_i),
        .b_req_i    (c1_req_i),
        .b_we_i     (c1_we_i),
        .b_addr_i   (c1_addr_i),
        .b_wdata_i  (c1_wdata_i),
        .b_be_i     (c1_be_i),
        .mismatch_o (lock_mismatch_o)
    );

    assign c0_rst_n_o  = rel0;
    assign c1_rst_n_o  = rel1;
    assign lockstep_o  = lock;
    assign seq_viol_o  = viol;

    assign c0_rvalid_o = r0_q.vld;
    assign c0_aerr_o   = r0_q.err;
    assign c0_rdata_o  = (r0_q.vld & ~r0_q.err) ?
                         (r0_q.bank ? bk_rdata[1] : bk_rdata[0]) : '0;
    assign c1_rvalid_o = r1_q.vld;
    assign c1_aerr_o   = r1_q.err;
    assign c1_rdata_o  = (r1_q.vld & ~r1_q.err) ? bk_rdata[1] : '0;

    assert_shadow_port_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (!c1_rvalid_o && !c1_aerr_o && c1_rdata_o == '0));

    assert_range_err_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
        c0_aerr_o |-> (c0_rvalid_o && c0_rdata_o == '0 && !lock));

    assert_resp_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rel0 && c0_req_i) |=> c0_rvalid_o);

    assert_no_resp_in_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rel0 && c0_req_i) |=> !c0_rvalid_o);

endmodule

// File: tb/dcl_pair_ctrl_bench.sv
`timescale 1ns/1ps
module dcl_pair_ctrl_bench;

    localparam int BANK_AW = 3;
    localparam int DW      = 32;
    localparam int WORDS   = 1 << BANK_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lockstep_sel_i = 1'b0;
    logic        c0_run_i = 1'b0, c1_run_i = 1'b0;
    logic        c0_rst_n_o, c1_rst_n_o, lockstep_o, seq_viol_o, lock_mismatch_o;
    logic        c0_req_i = 1'b0, c0_we_i = 1'b0;
    logic [3:0]  c0_addr_i = '0, c0_be_i = '0;
    logic [31:0] c0_wdata_i = '0;
    logic        c0_rvalid_o, c0_aerr_o;
    logic [31:0] c0_rdata_o;
    logic        c1_req_i = 1'b0, c1_we_i = 1'b0;
    logic [3:0]  c1_addr_i = '0, c1_be_i = '0;
    logic [31:0] c1_wdata_i = '0;
    logic        c1_rvalid_o, c1_aerr_o;
    logic [31:0] c1_rdata_o;

    int vectors = 0;
    int fails   = 0;
    logic [31:0] m0 [WORDS];
    logic [31:0] m1 [WORDS];

    always #4 clk = ~clk;

    dcl_pair_ctrl #(.BANK_AW(BANK_AW), .DW(DW)) u_dcl_pair_ctrl (
        .clk(clk), .rst_n(rst_n), .lockstep_sel_i(lockstep_sel_i),
        .c0_run_i(c0_run_i), .c1_run_i(c1_run_i),
        .c0_rst_n_o(c0_rst_n_o), .c1_rst_n_o(c1_rst_n_o),
        .lockstep_o(lockstep_o), .seq_viol_o(seq_viol_o),
        .lock_mismatch_o(lock_mismatch_o),
        .c0_req_i(c0_req_i), .c0_we_i(c0_we_i), .c0_addr_i(c0_addr_i),
        .c0_wdata_i(c0_wdata_i), .c0_be_i(c0_be_i),
        .c0_rvalid_o(c0_rvalid_o), .c0_rdata_o(c0_rdata_o), .c0_aerr_o(c0_aerr_o),
        .c1_req_i(c1_req_i), .c1_we_i(c1_we_i), .c1_addr_i(c1_addr_i),
        .c1_wdata_i(c1_wdata_i), .c1_be_i(c1_be_i),
        .c1_rvalid_o(c1_rvalid_o), .c1_rdata_o(c1_rdata_o), .c1_aerr_o(c1_aerr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Drive both ports for one cycle, then return them to idle.
    task automatic xfer(input logic r0, input logic w0, input logic [3:0] a0,
                        input logic [31:0] d0, input logic [3:0] b0,
                        input logic r1, input logic w1, input logic [3:0] a1,
                        input logic [31:0] d1, input logic [3:0] b1);
        c0_req_i = r0; c0_we_i = w0; c0_addr_i = a0; c0_wdata_i = d0; c0_be_i = b0;
        c1_req_i = r1; c1_we_i = w1; c1_addr_i = a1; c1_wdata_i = d1; c1_be_i = b1;
        tick();
        c0_req_i = 0; c0_we_i = 0; c0_addr_i = '0; c0_wdata_i = '0; c0_be_i = '0;
        c1_req_i = 0; c1_we_i = 0; c1_addr_i = '0; c1_wdata_i = '0; c1_be_i = '0;
    endtask

    task automatic mirror(input logic w, input logic [3:0] a, input logic [31:0] d,
                          input logic [3:0] b);
        xfer(1'b1, w, a, d, b, 1'b1, w, a, d, b);
    endtask

    task automatic do_reset(input logic lk);
        rst_n = 0; lockstep_sel_i = lk; c0_run_i = 0; c1_run_i = 0;
        repeat (3) tick();
        chk("R4 reset c0_rst_n", c0_rst_n_o, 0);
        chk("R4 reset c1_rst_n", c1_rst_n_o, 0);
        chk("R6 reset viol", seq_viol_o, 0);
        chk("R7 reset mismatch", lock_mismatch_o, 0);
        chk("R1 mode in reset", lockstep_o, lk);
        rst_n = 1;
        lockstep_sel_i = ~lk;
        tick();
        tick();
        chk("R1 mode frozen", lockstep_o, lk);
    endtask

    function automatic logic [31:0] pa(input int a);
        return 32'hA0A0_0000 + a * 32'h0000_1111;
    endfunction
    function automatic logic [31:0] pb(input int a);
        return 32'h5B00_0000 ^ (a << 12) ^ (a * 3);
    endfunction
    function automatic logic [31:0] pc(input int a);
        return 32'hC3C3_0000 | (a << 4) | a;
    endfunction
    function automatic logic [31:0] bmask(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int i = 0; i < 4; i++) if (be[i]) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // ---------------- split mode ----------------
        #1;
        do_reset(1'b0);
        chk("R12 idle rvalid", c0_rvalid_o, 0);

        // Core 1 release attempted while core 0 is held
        c1_run_i = 1;
        tick();
        chk("R3 c1 blocked", c1_rst_n_o, 0);
        chk("R6 viol set", seq_viol_o, 1);
        tick();
        chk("R6 viol sticky", seq_viol_o, 1);

        // Both requested: core 0 first, core 1 one edge later
        c0_run_i = 1;
        tick();
        chk("R4 c0 released", c0_rst_n_o, 1);
        chk("R4 c1 still held", c1_rst_n_o, 0);
        tick();
        chk("R4 c1 released", c1_rst_n_o, 1);

        // Independent banks, same addresses, different data
        for (int a = 0; a < WORDS; a++) begin
            xfer(1, 1, a[3:0], pa(a), 4'hF, 1, 1, a[3:0], pb(a), 4'hF);
            chk("R12 c0 write resp", c0_rvalid_o, 1);
            chk("R12 c1 write resp", c1_rvalid_o, 1);
            m0[a] = pa(a); m1[a] = pb(a);
        end
        for (int a = 0; a < WORDS; a++) begin
            xfer(1, 0, a[3:0], '0, 4'hF, 1, 0, a[3:0], '0, 4'hF);
            chk("R2 c0 own data", c0_rdata_o, m0[a]);
            chk("R2 c1 own data", c1_rdata_o, m1[a]);
            chk("R12 read valid", c0_rvalid_o, 1);
        end

        // All byte-strobe patterns on core 0
        for (int b = 0; b < 16; b++) begin
            xfer(1, 1, 4'd5, 32'h0, 4'hF, 0, 0, '0, '0, '0);
            xfer(1, 1, 4'd5, 32'hFFFF_FFFF, b[3:0], 0, 0, '0, '0, '0);
            xfer(1, 0, 4'd5, '0, 4'hF, 0, 0, '0, '0, '0);
            chk("R2 byte strobes", c0_rdata_o, bmask(b[3:0]));
        end
        m0[5] = 32'hFFFF_FFFF;
        xfer(0, 0, '0, '0, '0, 1, 0, 4'd5, '0, 4'hF);
        chk("R2 c1 untouched", c1_rdata_o, m1[5]);

        // Out-of-range in split mode
        for (int a = 0; a < WORDS; a++) begin
            xfer(1, 1, 4'(a + 8), 32'hDEAD_BEEF, 4'hF, 1, 0, 4'(a + 8), '0, 4'hF);
            chk("R11 c0 rvalid", c0_rvalid_o, 1);
            chk("R11 c0 aerr", c0_aerr_o, 1);
            chk("R11 c0 rdata", c0_rdata_o, 0);
            chk("R11 c1 aerr", c1_aerr_o, 1);
            xfer(1, 0, a[3:0], '0, 4'hF, 0, 0, '0, '0, '0);
            chk("R11 no write", c0_rdata_o, m0[a]);
            chk("R11 in-range aerr", c0_aerr_o, 0);
        end

        // Core 0 back into reset pulls core 1 with it
        c0_run_i = 0;
        tick();
        chk("R4 c0 re-held", c0_rst_n_o, 0);
        chk("R3 c1 re-held", c1_rst_n_o, 0);
        chk("R6 viol kept", seq_viol_o, 1);
        xfer(1, 0, 4'd1, '0, 4'hF, 1, 0, 4'd1, '0, 4'hF);
        chk("R12 held c0 no resp", c0_rvalid_o, 0);
        chk("R12 held c1 no resp", c1_rvalid_o, 0);

        // ---------------- lockstep mode ----------------
        do_reset(1'b1);
        c1_run_i = 1;
        tick();
        chk("R5 c1_run ignored", c1_rst_n_o, 0);
        chk("R6 no viol in lock", seq_viol_o, 0);
        c1_run_i = 0; c0_run_i = 1;
        tick();
        chk("R5 c0 released", c0_rst_n_o, 1);
        chk("R5 c1 same edge", c1_rst_n_o, 1);

        // Stacked view: upper half is core 1's former bank
        for (int a = 0; a < 2 * WORDS; a++) begin
            mirror(0, a[3:0], '0, 4'hF);
            chk("R10 stacked read", c0_rdata_o, (a < WORDS) ? m0[a] : m1[a - WORDS]);
            chk("R9 c1 rvalid off", c1_rvalid_o, 0);
            chk("R9 c1 rdata off", c1_rdata_o, 0);
        end
        for (int a = 0; a < WORDS; a++) begin
            mirror(1, 4'(a + 8), pc(a), 4'hF);
            m1[a] = pc(a);
            mirror(0, 4'(a + 8), '0, 4'hF);
            chk("R10 upper write", c0_rdata_o, m1[a]);
        end
        chk("R7 no mismatch mirrored", lock_mismatch_o, 0);
        xfer(1, 0, 4'd3, 32'h1234_5678, 4'hF, 1, 0, 4'd3, 32'h8765_4321, 4'hF);
        tick();
        chk("R8 read wdata ignored", lock_mismatch_o, 0);

        // One differing field per fresh reset
        for (int k = 0; k < 5; k++) begin
            do_reset(1'b1);
            c0_run_i = 1;
            tick();
            case (k)
                0: xfer(1, 1, 4'd2, pc(k + 9), 4'hF, 0, 1, 4'd2, pc(k + 9), 4'hF);
                1: xfer(1, 1, 4'd2, pc(k + 9), 4'hF, 1, 0, 4'd2, pc(k + 9), 4'hF);
                2: xfer(1, 1, 4'd2, pc(k + 9), 4'hF, 1, 1, 4'd10, 32'h0BAD_0BAD, 4'hF);
                3: xfer(1, 1, 4'd2, pc(k + 9), 4'hF, 1, 1, 4'd2, pc(k + 9), 4'h7);
                default: xfer(1, 1, 4'd2, pc(k + 9), 4'hF, 1, 1, 4'd2, ~pc(k + 9), 4'hF);
            endcase
            m0[2] = pc(k + 9);
            chk("R7 mismatch raised", lock_mismatch_o, 1);
            tick();
            tick();
            chk("R7 mismatch sticky", lock_mismatch_o, 1);
            xfer(1, 0, 4'd10, '0, 4'hF, 0, 0, '0, '0, '0);
            chk("R9 c1 write dropped", c0_rdata_o, m1[2]);
            xfer(1, 0, 4'd2, '0, 4'hF, 0, 0, '0, '0, '0);
            chk("R10 c0 write kept", c0_rdata_o, m0[2]);
        end

        // Back to split: core 1 sees what lockstep wrote in the upper half
        do_reset(1'b0);
        c0_run_i = 1; c1_run_i = 1;
        tick();
        tick();
        chk("R4 split release", c1_rst_n_o, 1);
        chk("R6 viol cleared", seq_viol_o, 0);
        for (int a = 0; a < WORDS; a++) begin
            xfer(1, 0, a[3:0], '0, 4'hF, 1, 0, a[3:0], '0, 4'hF);
            chk("R10 c1 sees stacked data", c1_rdata_o, m1[a]);
            chk("R2 c0 data kept", c0_rdata_o, m0[a]);
        end

        finish_run();
    end

endmodule